// File: doc/BRIEF.md
# SPI Receive Queue with Overflow Drop

This block is the receive-side word queue of a serial peripheral controller. Each time the serial engine finishes a transfer, it presents the shifted-in word with a one-cycle write strobe. The word goes into the queue with no host involvement. The host drains the queue one word at a time with a read strobe. Every read gets a registered acknowledge one cycle later, and an empty read also raises an error flag. A live occupancy count is always visible to the host.

Two single-cycle interrupt strobes report queue conditions. One marks the moment the queue fills. The other marks a word from the serial side that arrived with no free slot. That word is discarded and the stored words stay untouched. A write and a read in the same cycle are both honoured, even when the queue is full, because the read frees the slot the write needs.

Top module: `spi_rx_queue`

## Requirements
- R1: While reset is asserted and on the first cycle after it, occupancy is 0 and host_ack, host_err, irq_full, irq_ovf and host_rdata are all 0.
- R2: A shift_wr strobe with no read, on a queue that is not full, raises occupancy by one on the next cycle.
- R3: A host_rd on a non-empty queue has these effects on the next cycle: host_ack is 1, host_err is 0, host_rdata holds the oldest stored word (first in, first out), and occupancy is one lower. Order is kept across pointer wraparound.
- R4: A host_rd on an empty queue has these effects on the next cycle: host_ack is 1, host_err is 1, host_rdata is 0, and occupancy stays 0.
- R5: A shift_wr and a host_rd in the same cycle on a non-empty queue leave occupancy unchanged. The oldest word is returned and the new word is stored.
- R6: irq_full pulses high for exactly one cycle, on the cycle after occupancy first reaches DEPTH. It stays low while the queue remains full.
- R7: A shift_wr with no read while the queue is full drops the word. irq_ovf pulses for one cycle, occupancy stays at DEPTH, and the stored words are read back unchanged afterwards.
- R8: A shift_wr and a host_rd in the same cycle while full accept the new word. irq_ovf stays low and occupancy stays at DEPTH.
- R9: occupancy never exceeds DEPTH. In any cycle where neither strobe was given, occupancy does not change, and host_ack, host_rdata and both interrupts are 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shift_wr | input | 1 | Completed-transfer strobe from the serial engine |
| shift_data | input | W | Word captured by the serial engine |
| host_rd | input | 1 | Host read strobe |
| host_rdata | output | W | Read word, registered; 0 when no word was popped |
| host_ack | output | 1 | Acknowledge, one cycle after host_rd |
| host_err | output | 1 | Set with host_ack when the read found the queue empty |
| occupancy | output | $clog2(DEPTH+1) | Number of stored words |
| irq_full | output | 1 | One-cycle strobe on the transition to full |
| irq_ovf | output | 1 | One-cycle strobe when an incoming word is dropped |

## Verification
The hardest case to reach is a queue held exactly at DEPTH while the serial side keeps writing. The bench has to tell a dropped word (R7) apart from a same-cycle write and read that is accepted (R8). It must also show that the dropped words never appear in the later read stream. The stimulus fills the queue with a known ascending pattern and then issues unmatched writes with marker values. Next it issues paired write/read cycles at full, and finally it drains everything. The behavioural queue model predicts every popped word, so any marker that leaks into storage shows up as a data mismatch. A long random phase then keeps occupancy near the top and bottom edges so that wraparound is exercised many times.

// File: rtl/spi_rxq_pkg.sv
package spi_rxq_pkg;
  typedef struct packed {
    logic push;
    logic pop;
    logic drop;
  } rxq_op_t;
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] slot [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic slot_en;
    assign slot_en = we && (waddr == AW'(i));
    always_ff @(posedge clk) begin
      if (slot_en) slot[i] <= wdata;
    end
  end

  assign rdata = slot[raddr];
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import spi_rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift_wr,
  input  logic          host_rd,
  output rxq_op_t       op,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full_evt
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

  logic          full;
  logic [AW-1:0] wr_ptr_nxt, rd_ptr_nxt;
  logic [CW-1:0] count_nxt;

  assign empty = (count == '0);
  assign full  = (count == FULL_CNT);

  always_comb begin
    op.pop  = host_rd && !empty;
    op.push = shift_wr && (!full || op.pop);
    op.drop = shift_wr && full && !op.pop;
  end

  always_comb begin
    wr_ptr_nxt = wr_ptr;
    rd_ptr_nxt = rd_ptr;
    count_nxt  = count;
    if (op.push) wr_ptr_nxt = (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
    if (op.pop)  rd_ptr_nxt = (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
    case ({op.push, op.pop})
      2'b10:   count_nxt = count + 1'b1;
      2'b01:   count_nxt = count - 1'b1;
      default: count_nxt = count;
    endcase
  end

  assign full_evt = (count_nxt == FULL_CNT) && !full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (op.push) wr_ptr <= wr_ptr_nxt;
      if (op.pop)  rd_ptr <= rd_ptr_nxt;
      if (op.push ^ op.pop) count <= count_nxt;
    end
  end
endmodule

// File: rtl/rxq_resp.sv
module rxq_resp
  import spi_rxq_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         host_rd,
  input  logic         empty,
  input  rxq_op_t      op,
  input  logic [W-1:0] head,
  input  logic         full_evt,
  output logic         ack,
  output logic         err,
  output logic [W-1:0] rdata,
  output logic         irq_full,
  output logic         irq_ovf
);
  logic         ack_nxt, err_nxt, irq_full_nxt, irq_ovf_nxt;
  logic [W-1:0] rdata_nxt;

  always_comb begin
    ack_nxt      = host_rd;
    err_nxt      = host_rd && empty;
    rdata_nxt    = op.pop ? head : '0;
    irq_full_nxt = full_evt;
    irq_ovf_nxt  = op.drop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack      <= 1'b0;
      err      <= 1'b0;
      rdata    <= '0;
      irq_full <= 1'b0;
      irq_ovf  <= 1'b0;
    end else begin
      ack      <= ack_nxt;
      err      <= err_nxt;
      rdata    <= rdata_nxt;
      irq_full <= irq_full_nxt;
      irq_ovf  <= irq_ovf_nxt;
    end
  end
endmodule

// File: rtl/spi_rx_queue.sv
module spi_rx_queue
  import spi_rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift_wr,
  input  logic [W-1:0]  shift_data,
  input  logic          host_rd,
  output logic [W-1:0]  host_rdata,
  output logic          host_ack,
  output logic          host_err,
  output logic [CW-1:0] occupancy,
  output logic          irq_full,
  output logic          irq_ovf
);
  rxq_op_t       op;
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [W-1:0]  head;
  logic          empty, full_evt;

  rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_wr (shift_wr),
    .host_rd  (host_rd),
    .op       (op),
    .wr_ptr   (wr_ptr),
    .rd_ptr   (rd_ptr),
    .count    (occupancy),
    .empty    (empty),
    .full_evt (full_evt)
  );

  rxq_store #(.DEPTH(DEPTH), .W(W)) u_store (
    .clk   (clk),
    .we    (op.push),
    .waddr (wr_ptr),
    .wdata (shift_data),
    .raddr (rd_ptr),
    .rdata (head)
  );

  rxq_resp #(.W(W)) u_resp (
    .clk      (clk),
    .rst_n    (rst_n),
    .host_rd  (host_rd),
    .empty    (empty),
    .op       (op),
    .head     (head),
    .full_evt (full_evt),
    .ack      (host_ack),
    .err      (host_err),
    .rdata    (host_rdata),
    .irq_full (irq_full),
    .irq_ovf  (irq_ovf)
  );
endmodule

// File: rtl/spi_rxq_checker.sv
module spi_rxq_checker #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          shift_wr,
  input logic          host_rd,
  input logic [W-1:0]  host_rdata,
  input logic          host_ack,
  input logic          host_err,
  input logic [CW-1:0] occupancy,
  input logic          irq_full,
  input logic          irq_ovf
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  // R1
  always_comb begin
    if (!rst_n) a_r1_reset_clear: assert (occupancy == '0 && !host_ack && !irq_full && !irq_ovf);
  end

  // R2
  a_r2_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_wr && !host_rd && occupancy != FULL_CNT) |=> (occupancy == $past(occupancy) + 1'b1));

  // R3
  a_r3_pop_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && occupancy != '0 && !shift_wr) |=> (host_ack && !host_err && occupancy == $past(occupancy) - 1'b1));

  // R4
  a_r4_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && occupancy == '0) |=> (host_ack && host_err && host_rdata == '0));

  // R5
  a_r5_pair_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_wr && host_rd && occupancy != '0) |=> ($stable(occupancy) && !host_err));

  // R6
  a_r6_full_once: assert property (@(posedge clk) disable iff (!rst_n)
    irq_full |-> (occupancy == FULL_CNT && $past(occupancy) != FULL_CNT));
  a_r6_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
    irq_full |=> !irq_full);

  // R7
  a_r7_drop_word: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_wr && !host_rd && occupancy == FULL_CNT) |=> (irq_ovf && occupancy == FULL_CNT));

  // R8
  a_r8_full_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_wr && host_rd && occupancy == FULL_CNT) |=> (!irq_ovf && occupancy == FULL_CNT));

  // R9
  a_r9_bound: assert property (@(posedge clk) disable iff (!rst_n) occupancy <= FULL_CNT);
  a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_wr && !host_rd) |=> ($stable(occupancy) && !host_ack && !irq_full && !irq_ovf));
endmodule

bind spi_rx_queue spi_rxq_checker #(.DEPTH(DEPTH), .W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .shift_wr   (shift_wr),
  .host_rd    (host_rd),
  .host_rdata (host_rdata),
  .host_ack   (host_ack),
  .host_err   (host_err),
  .occupancy  (occupancy),
  .irq_full   (irq_full),
  .irq_ovf    (irq_ovf)
);

// File: tb/sim_spi_rx_queue.sv
module sim_spi_rx_queue;
  localparam int DEPTH = 16;
  localparam int W     = 8;
  localparam int CW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          shift_wr = 1'b0;
  logic [W-1:0]  shift_data = '0;
  logic          host_rd = 1'b0;
  logic [W-1:0]  host_rdata;
  logic          host_ack, host_err, irq_full, irq_ovf;
  logic [CW-1:0] occupancy;

  int    n_run = 0;
  int    n_fail = 0;
  int    cycles = 0;
  string cur_req = "R1";

  logic [W-1:0] model_q[$];
  int exp_occ = 0, exp_ack = 0, exp_err = 0, exp_rdata = 0, exp_full = 0, exp_ovf = 0;

  always #10 clk = ~clk;

  spi_rx_queue #(.DEPTH(DEPTH), .W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .shift_wr(shift_wr), .shift_data(shift_data),
    .host_rd(host_rd), .host_rdata(host_rdata), .host_ack(host_ack),
    .host_err(host_err), .occupancy(occupancy), .irq_full(irq_full), .irq_ovf(irq_ovf)
  );

  task automatic check(string req, string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Behavioural reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      model_q.delete();
      exp_occ = 0; exp_ack = 0; exp_err = 0; exp_rdata = 0; exp_full = 0; exp_ovf = 0;
    end else begin
      automatic bit was_full = (model_q.size() == DEPTH);
      exp_ack = host_rd;
      exp_err = host_rd && (model_q.size() == 0);
      exp_rdata = 0;
      exp_ovf = 0;
      if (host_rd && model_q.size() != 0) exp_rdata = model_q.pop_front();
      if (shift_wr) begin
        if (model_q.size() < DEPTH) model_q.push_back(shift_data);
        else exp_ovf = 1;
      end
      exp_full = !was_full && (model_q.size() == DEPTH);
      exp_occ = model_q.size();
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      check(cur_req, "occupancy", occupancy, exp_occ);
      check(cur_req, "host_ack", host_ack, exp_ack);
      check(cur_req, "host_err", host_err, exp_err);
      check(cur_req, "host_rdata", host_rdata, exp_rdata);
      check(cur_req, "irq_full", irq_full, exp_full);
      check(cur_req, "irq_ovf", irq_ovf, exp_ovf);
      check("R9", "occupancy bound", int'(occupancy <= DEPTH), 1);
    end
    if (cycles > 100000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 100000", cycles);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic step(bit w, logic [W-1:0] d, bit r);
    shift_wr = w; shift_data = d; host_rd = r;
    @(negedge clk);
    shift_wr = 1'b0; host_rd = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state observed at the ports
    check("R1", "occupancy in reset", occupancy, 0);
    check("R1", "irq in reset", irq_full | irq_ovf, 0);
    check("R1", "ack in reset", host_ack | host_err, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "rdata after reset", host_rdata, 0);

    cur_req = "R2";
    for (int i = 0; i < 3; i++) step(1'b1, W'(8'h10 + i), 1'b0);
    step(1'b0, '0, 1'b0);

    cur_req = "R3";
    for (int i = 0; i < 2; i++) step(1'b0, '0, 1'b1);

    cur_req = "R4";
    for (int i = 0; i < 3; i++) step(1'b0, '0, 1'b1);
    step(1'b0, '0, 1'b0);

    cur_req = "R5";
    step(1'b1, 8'h20, 1'b0);
    for (int i = 0; i < 5; i++) step(1'b1, W'(8'h21 + i), 1'b1);
    step(1'b0, '0, 1'b1);
    step(1'b1, 8'h30, 1'b1);
    step(1'b0, '0, 1'b1);

    cur_req = "R6";
    for (int i = 0; i < DEPTH; i++) step(1'b1, W'(8'h40 + i), 1'b0);
    step(1'b0, '0, 1'b0);
    step(1'b0, '0, 1'b0);

    cur_req = "R7";
    for (int i = 0; i < 3; i++) step(1'b1, W'(8'hE0 + i), 1'b0);

    cur_req = "R8";
    for (int i = 0; i < 4; i++) step(1'b1, W'(8'h60 + i), 1'b1);

    cur_req = "R3";
    for (int i = 0; i < DEPTH + 1; i++) step(1'b0, '0, 1'b1);

    cur_req = "R9";
    for (int i = 0; i < 3000; i++) begin
      automatic int bias = (i / 300) % 2;
      automatic bit w = ($urandom_range(0, 9) < (bias ? 7 : 3));
      automatic bit r = ($urandom_range(0, 9) < (bias ? 3 : 7));
      step(w, W'($urandom), r);
    end
    step(1'b0, '0, 1'b0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule